// File: doc/BRIEF.md
# Zero-Crossing FSK Receive Demodulator

This block recovers serial receive data from a two-tone FSK line signal after an external comparator has squared it to a single bit. The 1200 Hz tone carries a logic 1 (mark) and the 2200 Hz tone carries a logic 0 (space). The block is clocked at 460.8 kHz. It counts clock cycles between successive edges of the squared input and sorts each half-period against a fixed threshold. The latest decision drives `rxd_o`.

A carrier qualifier watches the same half-period lengths. It asserts `cd_o` only after a run of plausible half-periods, and it drops `cd_o` when an implausible half-period arrives or when the line goes quiet for too long. The line is half-duplex. While the local transmitter requests to send (`rts_ni` low), the receive path is held cleared. While there is no carrier or the transmitter is active, `rxd_o` idles at mark so that a downstream UART sees a steady line.

Top module: `fsk_zc_demod`

## Requirements
- R1: With carrier present, a mark tone (1190 to 1210 Hz) drives `rxd_o` to 1 and a space tone (2180 to 2220 Hz) drives `rxd_o` to 0.
- R2: On every input edge of either polarity, a half-period of 148 clocks or more is decoded as 1 and a half-period of 147 clocks or fewer is decoded as 0. The decision holds until the next edge.
- R3: For 384-clock bits with phase-continuous tones, every `rxd_o` change falls 40 to 310 clocks after the start of a bit whose value differs from the bit before it. No other change of `rxd_o` occurs.
- R4: `cd_o` rises after four consecutive half-periods of 80 to 260 clocks. After three such half-periods it is still low.
- R5: A half-period shorter than 80 or longer than 260 clocks clears the run and drops `cd_o`. A 4 kHz square wave never raises it.
- R6: When the input has no edge for more than 300 clocks, `cd_o` drops. The block adds a few clocks of synchronizer delay. `cd_o` is still high 290 clocks after the last edge and low by 320 clocks after it.
- R7: While `cd_o` is low or `rts_ni` is low, `rxd_o` is 1. `rts_ni` low forces `cd_o` low in the same cycle.
- R8: `rts_ni` low clears the receive state, so after it rises the carrier must be acquired again from a fresh run of four half-periods.
- R9: After the asynchronous active-low reset, `rxd_o` is 1 and `cd_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 460.8 kHz sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| comp_i | input | 1 | Squared receive signal from the comparator, asynchronous |
| rts_ni | input | 1 | Transmitter request-to-send, active low; blocks receive |
| rxd_o | output | 1 | Recovered data, idles at 1 |
| cd_o | output | 1 | Carrier present |

## Verification
Phase-continuous frames are sent with random data at the nominal tones and at each tolerance limit. Per-bit level checks confirm the mark/space mapping. Transition timing checks show that each output change follows a real bit change within a bounded window and that no stray change occurs. Directed edge trains are used for four further cases:
- 147- and 148-clock spacings locate the decision threshold.
- Three versus four in-window half-periods locate carrier acquisition.
- A 270-clock half-period and a 4 kHz train separate rejection by the length window from rejection by the quiet-line timeout.
- A request-to-send pulse during a space tone shows that output forcing and state clearing are distinct effects.

// File: rtl/fskd_pkg.sv
package fskd_pkg;
  localparam int unsigned DEF_CNT_W  = 9;
  localparam int unsigned DEF_SYNC_N = 2;
  localparam int unsigned DEF_THR    = 148;
  localparam int unsigned DEF_WIN_LO = 80;
  localparam int unsigned DEF_WIN_HI = 260;
  localparam int unsigned DEF_GAP    = 300;
  localparam int unsigned DEF_RUN_N  = 4;

  typedef enum logic {
    SYM_SPACE = 1'b0,
    SYM_MARK  = 1'b1
  } sym_e;
endpackage

// File: rtl/fskd_sync.sv
module fskd_sync #(
  parameter int unsigned SYNC_N = fskd_pkg::DEF_SYNC_N
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic comp_i,
  output logic tgl_o
);
  logic [SYNC_N:0] pipe_q;

  for (genvar g = 0; g <= SYNC_N; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[g] <= 1'b0;
        else         pipe_q[g] <= comp_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[g] <= 1'b0;
        else         pipe_q[g] <= pipe_q[g-1];
      end
    end
  end

  // last stage only delays, used for edge compare
  assign tgl_o = pipe_q[SYNC_N] ^ pipe_q[SYNC_N-1];
endmodule

// File: rtl/fskd_period.sv
module fskd_period #(
  parameter int unsigned CNT_W = fskd_pkg::DEF_CNT_W,
  parameter int unsigned GAP   = fskd_pkg::DEF_GAP
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tgl_i,
  output logic             vld_o,
  output logic [CNT_W-1:0] len_o,
  output logic             gap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] GAP_C   = CNT_W'(GAP);

  logic [CNT_W-1:0] cnt_q, cnt_inc;
  logic             vld_q;
  logic [CNT_W-1:0] len_q;

  assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      vld_q <= 1'b0;
      len_q <= '0;
    end else if (!en_i) begin
      cnt_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= tgl_i;
      if (tgl_i) begin
        len_q <= cnt_inc;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_inc;
      end
    end
  end

  assign vld_o = vld_q;
  assign len_o = len_q;
  assign gap_o = cnt_q > GAP_C;

  p_cnt_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && tgl_i |=> (cnt_q == '0));
  p_evt_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && tgl_i |=> vld_o);
  p_gap_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_o |-> !$past(tgl_i && en_i));
endmodule

// File: rtl/fskd_carrier.sv
module fskd_carrier #(
  parameter int unsigned CNT_W  = fskd_pkg::DEF_CNT_W,
  parameter int unsigned WIN_LO = fskd_pkg::DEF_WIN_LO,
  parameter int unsigned WIN_HI = fskd_pkg::DEF_WIN_HI,
  parameter int unsigned RUN_N  = fskd_pkg::DEF_RUN_N
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             vld_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             gap_i,
  output logic             cd_o
);
  localparam int unsigned      RUN_W   = $clog2(RUN_N + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_N);
  localparam logic [RUN_W-1:0] RUN_PRE = RUN_W'(RUN_N - 1);
  localparam logic [CNT_W-1:0] LO_C    = CNT_W'(WIN_LO);
  localparam logic [CNT_W-1:0] HI_C    = CNT_W'(WIN_HI);

  logic [RUN_W-1:0] run_q;
  logic             cd_q;
  logic             in_win;

  assign in_win = (len_i >= LO_C) && (len_i <= HI_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      cd_q  <= 1'b0;
    end else if (!en_i || gap_i) begin
      run_q <= '0;
      cd_q  <= 1'b0;
    end else if (vld_i) begin
      if (in_win) begin
        if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
        if (run_q >= RUN_PRE) cd_q <= 1'b1;
      end else begin
        run_q <= '0;
        cd_q  <= 1'b0;
      end
    end
  end

  assign cd_o = cd_q;

  p_cd_rise_on_evt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cd_q) |-> $past(vld_i && en_i));
  p_gap_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_i |=> !cd_q);
  p_outwin_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i && ((len_i < LO_C) || (len_i > HI_C)) |=> !cd_q);
endmodule

// File: rtl/fskd_slicer.sv
module fskd_slicer #(
  parameter int unsigned CNT_W = fskd_pkg::DEF_CNT_W,
  parameter int unsigned THR   = fskd_pkg::DEF_THR
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             vld_i,
  input  logic [CNT_W-1:0] len_i,
  output fskd_pkg::sym_e   sym_o
);
  import fskd_pkg::*;
  localparam logic [CNT_W-1:0] THR_C = CNT_W'(THR);

  sym_e sym_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sym_q <= SYM_MARK;
    else if (!en_i)  sym_q <= SYM_MARK;
    else if (vld_i)  sym_q <= (len_i >= THR_C) ? SYM_MARK : SYM_SPACE;
  end

  assign sym_o = sym_q;

  p_hold_between_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !$past(vld_i) && $past(en_i) |-> $stable(sym_q));
  p_rts_mark_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (sym_q == SYM_MARK));
endmodule

// File: rtl/fsk_zc_demod.sv
module fsk_zc_demod #(
  parameter int unsigned CNT_W  = fskd_pkg::DEF_CNT_W,
  parameter int unsigned SYNC_N = fskd_pkg::DEF_SYNC_N,
  parameter int unsigned THR    = fskd_pkg::DEF_THR,
  parameter int unsigned WIN_LO = fskd_pkg::DEF_WIN_LO,
  parameter int unsigned WIN_HI = fskd_pkg::DEF_WIN_HI,
  parameter int unsigned GAP    = fskd_pkg::DEF_GAP,
  parameter int unsigned RUN_N  = fskd_pkg::DEF_RUN_N
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic comp_i,
  input  logic rts_ni,
  output logic rxd_o,
  output logic cd_o
);
  import fskd_pkg::*;

  logic             tgl_w, vld_w, gap_w, cd_w;
  logic [CNT_W-1:0] len_w;
  sym_e             sym_w;

  fskd_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .comp_i(comp_i), .tgl_o(tgl_w)
  );

  fskd_period #(.CNT_W(CNT_W), .GAP(GAP)) u_period (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(rts_ni), .tgl_i(tgl_w),
    .vld_o(vld_w), .len_o(len_w), .gap_o(gap_w)
  );

  fskd_carrier #(.CNT_W(CNT_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .RUN_N(RUN_N)) u_carrier (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(rts_ni), .vld_i(vld_w),
    .len_i(len_w), .gap_i(gap_w), .cd_o(cd_w)
  );

  fskd_slicer #(.CNT_W(CNT_W), .THR(THR)) u_slicer (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(rts_ni), .vld_i(vld_w),
    .len_i(len_w), .sym_o(sym_w)
  );

  // transmit request gates combinationally so the line idles at once
  assign cd_o  = cd_w && rts_ni;
  assign rxd_o = cd_o ? (sym_w == SYM_MARK) : 1'b1;

  p_rts_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rts_ni |=> !cd_w);
endmodule

// File: tb/fsk_zc_demod_test.sv
module fsk_zc_demod_test;
  localparam int BIT_CLK = 384;
  localparam int PRE     = 5;
  localparam int WD_MAX  = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic comp = 1'b0;
  logic rts_n = 1'b1;
  logic rxd, cd;

  int  errors = 0;
  int  checks = 0;
  int  wd = 0;
  int  since = 0;
  bit  done = 1'b0;
  real ph = 0.0;

  always #5 clk = ~clk;

  fsk_zc_demod uut (
    .clk_i(clk), .rst_ni(rst_n), .comp_i(comp), .rts_ni(rts_n),
    .rxd_o(rxd), .cd_o(cd)
  );

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd >= WD_MAX && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", wd, WD_MAX);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick_tone(input real f);
    @(negedge clk);
    ph = ph + 2.0 * f / 460800.0;
    if (ph >= 1.0) begin ph = ph - 1.0; comp = ~comp; since = 0; end
    else since++;
  endtask

  task automatic tick_hold(input bit flip);
    @(negedge clk);
    if (flip) begin comp = ~comp; since = 0; end
    else since++;
  endtask

  task automatic hold(input int n);
    repeat (n) tick_hold(1'b0);
  endtask

  // n edges, each sp clocks after the previous event
  task automatic edges(input int sp, input int n);
    repeat (n) begin
      repeat (sp - 1) tick_hold(1'b0);
      tick_hold(1'b1);
    end
  endtask

  task automatic tone(input real f, input int n);
    repeat (n) tick_tone(f);
  endtask

  function automatic real pick_mark(input int s);
    return (s == 0) ? 1190.0 : (s == 1) ? 1200.0 : 1210.0;
  endfunction
  function automatic real pick_space(input int s);
    return (s == 0) ? 2180.0 : (s == 1) ? 2200.0 : 2220.0;
  endfunction

  // mode 0: random data, mode 1: alternating data
  task automatic frame(input real fm, input real fs, input int mode);
    logic [31:0] bits;
    int nb, exp_tr, got_tr, last_b;
    logic prev;
    nb = PRE + 16 + 1;
    bits = '0;
    for (int i = 0; i < nb; i++) begin
      if (i < PRE || i == nb - 1) bits[i] = 1'b1;
      else if (mode == 1)         bits[i] = i[0];
      else                        bits[i] = 1'($urandom % 2);
    end
    exp_tr = 0;
    for (int i = PRE; i < nb; i++) if (bits[i] != bits[i-1]) exp_tr++;
    got_tr = 0; last_b = -1; prev = 1'b1; ph = 0.0;
    for (int k = 0; k < nb * BIT_CLK; k++) begin
      int b, d;
      b = k / BIT_CLK; d = k % BIT_CLK;
      tick_tone(bits[b] ? fm : fs);
      if (k == PRE * BIT_CLK) begin
        chk(cd == 1'b1, "R4 carrier after preamble", int'(cd), 1);
        prev = rxd;
      end
      if (k > PRE * BIT_CLK && rxd != prev) begin
        got_tr++;
        chk(b >= PRE && bits[b] != bits[b-1] && d >= 40 && d <= 310 && last_b != b,
            "R3 transition window", d, 175);
        last_b = b;
      end
      if (k >= PRE * BIT_CLK) prev = rxd;
      if (b >= PRE - 1 && d == 340)
        chk(rxd == bits[b], "R1 bit level", int'(rxd), int'(bits[b]));
    end
    chk(got_tr == exp_tr, "R3 transition count", got_tr, exp_tr);
    hold(500);
  endtask

  initial begin
    int ok;
    void'($urandom(32'h5eed_0a11));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    hold(4);
    chk(rxd == 1'b1, "R9 reset rxd", int'(rxd), 1);
    chk(cd == 1'b0, "R9 reset cd", int'(cd), 0);

    // R2 threshold
    hold(400);
    edges(105, 6); hold(10);
    chk(cd == 1'b1, "R2 space carrier", int'(cd), 1);
    chk(rxd == 1'b0, "R2 105 clocks is space", int'(rxd), 0);
    edges(138, 1); hold(10);
    chk(rxd == 1'b1, "R2 148 clocks is mark", int'(rxd), 1);
    edges(137, 1); hold(10);
    chk(rxd == 1'b0, "R2 147 clocks is space", int'(rxd), 0);
    edges(138, 1); hold(10);
    chk(rxd == 1'b1, "R2 148 clocks again mark", int'(rxd), 1);

    // R4 run of four
    hold(400);
    edges(192, 4); hold(10);
    chk(cd == 1'b0, "R4 three periods no carrier", int'(cd), 0);
    edges(182, 1); hold(10);
    chk(cd == 1'b1, "R4 four periods carrier", int'(cd), 1);

    // R5 window
    hold(400);
    edges(57, 12); hold(10);
    chk(cd == 1'b0, "R5 4kHz no carrier", int'(cd), 0);
    chk(rxd == 1'b1, "R5 idle mark", int'(rxd), 1);
    hold(400);
    edges(192, 6); hold(10);
    chk(cd == 1'b1, "R5 carrier before long period", int'(cd), 1);
    edges(260, 1); hold(10);
    chk(cd == 1'b0, "R5 270 clock period drops", int'(cd), 0);
    chk(rxd == 1'b1, "R5 rxd idle after drop", int'(rxd), 1);

    // R6 quiet line
    hold(400);
    edges(192, 6);
    hold(290);
    chk(cd == 1'b1, "R6 held at 290", int'(cd), 1);
    hold(30);
    chk(cd == 1'b0, "R6 dropped by 320", int'(cd), 0);
    chk(rxd == 1'b1, "R6 rxd idle", int'(rxd), 1);

    // R7 / R8 transmit request
    hold(400); ph = 0.0;
    tone(2200.0, 2000);
    chk(cd == 1'b1 && rxd == 1'b0, "R1 steady space", int'(rxd), 0);
    rts_n = 1'b0; #1;
    chk(rxd == 1'b1 && cd == 1'b0, "R7 same cycle block", int'(rxd), 1);
    ok = 1;
    repeat (400) begin
      tick_tone(2200.0);
      if (rxd != 1'b1 || cd != 1'b0) ok = 0;
    end
    chk(ok == 1, "R7 blocked during rts", ok, 1);
    rts_n = 1'b1;
    tone(2200.0, 20);
    chk(cd == 1'b0, "R8 state cleared after rts", int'(cd), 0);
    tone(2200.0, 1200);
    chk(cd == 1'b1 && rxd == 1'b0, "R8 reacquired", int'(rxd), 0);
    hold(500);

    // R1 / R3 frames: limits and random
    frame(1190.0, 2220.0, 1);
    frame(1210.0, 2180.0, 1);
    for (int n = 0; n < 6; n++)
      frame(pick_mark(int'($urandom % 3)), pick_space(int'($urandom % 3)), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule